// File: doc/BRIEF.md
# Daisy-Chain Interrupt Acknowledge Chain

This block resolves interrupt priority by chain position. It is built from a row of identical links. Each link holds a pending flag for its own interrupt source and a programmable vector of `IRQ_VEC_W` bits. The pending flags of all links are ORed onto one shared request line for the processor. The line stays low whenever no link is pending.

The processor answers the shared request by raising its acknowledge. The acknowledge enters link 0, which is nearest the processor and has the highest priority. Acknowledge travels from link to link through each link's priority-in and priority-out. A link with nothing pending passes the acknowledge on to the next link. The first pending link it reaches keeps it, stops it from travelling further and drives its own vector onto the shared vector path.

The vector counts as taken when the acknowledge falls while a link is driving its vector. At that point the link's pending flag clears.

Top module: `irq_daisy_chain`

## Requirements
- R1: `irq_line` is high exactly when at least one link is pending, and it is 0 when no link is pending.
- R2: A high `src_req[k]` at a clock edge makes link k pending after that edge, so `irq_line` is high one cycle after the request is sampled.
- R3: With `cpu_ack` high and link 0 pending, `granted` is 4'b0001 in the same cycle, `vec_valid` is 1, `vec_data` carries link 0's vector and `chain_po` is 0.
- R4: A link that is not pending passes acknowledge on, so the pending link with the lowest index is granted and supplies its vector.
- R5: With `cpu_ack` high and no link pending, the acknowledge reaches `chain_po`, `vec_valid` is 0 and `vec_data` is all zeros.
- R6: A link that was granted in the previous cycle, and now sees `cpu_ack` low, leaves the pending state at this edge. Other pending links are unaffected.
- R7: At most one bit of `granted` is ever set, and this holds when a request arrives while acknowledge is already high.
- R8: After reset the vector of link k is `VEC_BASE + k`. A high `cfg_load[k]` at an edge writes `cfg_vec` into link k's vector. Without a load, the vector holds.
- R9: If a new `src_req[k]` coincides with the edge that would clear link k, link k stays pending.
- R10: A request that arrives at an upstream link while acknowledge is high takes over the grant in the cycle after it is sampled. The downstream link loses the grant but stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | N | Local interrupt request per link, bit k for link k |
| cfg_load | input | N | Vector write strobe per link |
| cfg_vec | input | IRQ_VEC_W | Vector value written by `cfg_load` |
| cpu_ack | input | 1 | Processor acknowledge into link 0 |
| irq_line | output | 1 | Shared request line, OR of all pending flags |
| vec_data | output | IRQ_VEC_W | OR of the link vector outputs |
| vec_valid | output | 1 | A link is driving its vector |
| chain_po | output | 1 | Priority-out of the last link |
| granted | output | N | One-hot flag of the link that holds acknowledge |

## Verification
Each result of this block falls into one of two timing classes:
- **Same cycle:** the grant, the vector, the priority-out and the shared line follow the pending flags and `cpu_ack` through logic only. The bench checks them one time unit after it changes an input, inside the same cycle.
- **One edge later:** setting a pending flag, clearing it and loading a vector each take effect at the next clock edge. The bench checks these results just after that edge, before it applies new stimulus.

Clearing a flag needs the grant to be registered at one edge and a low acknowledge at the following edge. The bench therefore drops the acknowledge only after one full cycle of grant.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    localparam int IRQ_VEC_W = 8;

    typedef logic [IRQ_VEC_W-1:0] irq_vec_t;

    // Combinational outputs of one chain link
    typedef struct packed {
        logic     pending;
        logic     grant;
        logic     pass;
        irq_vec_t vec;
    } link_out_t;

    // Reset vector of link k
    function automatic irq_vec_t reset_vec(input irq_vec_t base, input int k);
        return irq_vec_t'(base + irq_vec_t'(k));
    endfunction

endpackage

// File: rtl/irq_pending_reg.sv
module irq_pending_reg (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic grant_i,
    input  logic cpu_ack_i,
    output logic pending_o
);
    logic pending_q;
    logic grant_q;
    logic taken;

    // Vector taken: granted last cycle and acknowledge now low
    assign taken = grant_q & ~cpu_ack_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            grant_q   <= 1'b0;
        end else begin
            grant_q <= grant_i;
            if (req_i)
                pending_q <= 1'b1;
            else if (taken)
                pending_q <= 1'b0;
        end
    end

    assign pending_o = pending_q;

    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
        req_i |=> pending_o);

    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (grant_q && !cpu_ack_i && !req_i) |=> !pending_o);

endmodule

// File: rtl/irq_vec_reg.sv
module irq_vec_reg
    import irq_chain_pkg::*;
#(
    parameter irq_vec_t RST_VEC = '0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     load_i,
    input  irq_vec_t data_i,
    output irq_vec_t vec_o
);
    irq_vec_t vec_q;

    always_ff @(posedge clk) begin
        if (rst)
            vec_q <= RST_VEC;
        else if (load_i)
            vec_q <= data_i;
    end

    assign vec_o = vec_q;

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(vec_o));

endmodule

// File: rtl/irq_chain_node.sv
module irq_chain_node
    import irq_chain_pkg::*;
#(
    parameter irq_vec_t RST_VEC = '0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req_i,
    input  logic      load_i,
    input  irq_vec_t  cfg_vec_i,
    input  logic      cpu_ack_i,
    input  logic      pi_i,
    output link_out_t out_o
);
    logic     pending;
    logic     grant;
    irq_vec_t vec;

    irq_pending_reg u_pend (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req_i),
        .grant_i   (grant),
        .cpu_ack_i (cpu_ack_i),
        .pending_o (pending)
    );

    irq_vec_reg #(.RST_VEC(RST_VEC)) u_vec (
        .clk    (clk),
        .rst    (rst),
        .load_i (load_i),
        .data_i (cfg_vec_i),
        .vec_o  (vec)
    );

    // Keep acknowledge when pending, otherwise forward it
    assign grant = pi_i & pending;

    always_comb begin
        out_o.pending = pending;
        out_o.grant   = grant;
        out_o.pass    = pi_i & ~pending;
        out_o.vec     = grant ? vec : '0;
    end

    assert_block_R4: assert property (@(posedge clk) disable iff (rst)
        out_o.grant |-> !out_o.pass);

endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain
    import irq_chain_pkg::*;
#(
    parameter int       N        = 4,
    parameter irq_vec_t VEC_BASE = 8'h20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         src_req,
    input  logic [N-1:0]         cfg_load,
    input  logic [IRQ_VEC_W-1:0] cfg_vec,
    input  logic                 cpu_ack,
    output logic                 irq_line,
    output logic [IRQ_VEC_W-1:0] vec_data,
    output logic                 vec_valid,
    output logic                 chain_po,
    output logic [N-1:0]         granted
);
    link_out_t link [N];
    logic      pi     [N+1];
    irq_vec_t  vec_or [N+1];
    logic [N-1:0] pend_bits;

    assign pi[0]     = cpu_ack;
    assign vec_or[0] = '0;

    for (genvar k = 0; k < N; k++) begin : g_link
        irq_chain_node #(.RST_VEC(reset_vec(VEC_BASE, k))) u_node (
            .clk       (clk),
            .rst       (rst),
            .req_i     (src_req[k]),
            .load_i    (cfg_load[k]),
            .cfg_vec_i (cfg_vec),
            .cpu_ack_i (cpu_ack),
            .pi_i      (pi[k]),
            .out_o     (link[k])
        );
        assign pi[k+1]      = link[k].pass;
        assign vec_or[k+1]  = vec_or[k] | link[k].vec;
        assign pend_bits[k] = link[k].pending;
        assign granted[k]   = link[k].grant;
    end

    // Wired OR modelled as a logical OR
    assign irq_line  = |pend_bits;
    assign vec_data  = vec_or[N];
    assign vec_valid = |granted;
    assign chain_po  = pi[N];

    assert_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(granted));

    assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (pend_bits == '0) |-> !irq_line);

    assert_valid_R3: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (cpu_ack && !chain_po));

endmodule

// File: tb/irq_daisy_chain_tb_top.sv
module irq_daisy_chain_tb_top;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst;
    logic [N-1:0] src_req;
    logic [N-1:0] cfg_load;
    logic [7:0]   cfg_vec;
    logic         cpu_ack;
    logic         irq_line;
    logic [7:0]   vec_data;
    logic         vec_valid;
    logic         chain_po;
    logic [N-1:0] granted;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irq_daisy_chain #(.N(N), .VEC_BASE(8'h20)) dut_i (
        .clk(clk), .rst(rst), .src_req(src_req), .cfg_load(cfg_load),
        .cfg_vec(cfg_vec), .cpu_ack(cpu_ack), .irq_line(irq_line),
        .vec_data(vec_data), .vec_valid(vec_valid), .chain_po(chain_po),
        .granted(granted)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #1;
    endtask

    // Request one cycle on the given links
    task automatic pulse_req(input logic [N-1:0] m);
        src_req = m;
        step();
        src_req = '0;
        settle();
    endtask

    // Full acknowledge cycle: hold a cycle, then drop
    task automatic serve();
        cpu_ack = 1'b1;
        step();
        cpu_ack = 1'b0;
        step();
    endtask

    task automatic t_reset();
        chk("R1 reset irq_line", irq_line, 0);
        chk("R5 reset vec_valid", vec_valid, 0);
        chk("R7 reset granted", granted, 0);
        chk("reset chain_po", chain_po, 0);
    endtask

    task automatic t_passthrough();
        cpu_ack = 1'b1;
        settle();
        chk("R5 chain_po passes", chain_po, 1);
        chk("R5 vec_valid low", vec_valid, 0);
        chk("R5 vec_data zero", vec_data, 0);
        cpu_ack = 1'b0;
        step();
    endtask

    task automatic t_single();
        pulse_req(4'b0001);
        chk("R2 irq_line after request", irq_line, 1);
        cpu_ack = 1'b1;
        settle();
        chk("R3 granted link0", granted, 4'b0001);
        chk("R3 vec_data link0", vec_data, 8'h20);
        chk("R3 vec_valid", vec_valid, 1);
        chk("R3 chain_po blocked", chain_po, 0);
        step();
        cpu_ack = 1'b0;
        step();
        chk("R6 cleared after ack fall", irq_line, 0);
    endtask

    task automatic t_priority();
        pulse_req(4'b1010);
        chk("R1 irq_line two pending", irq_line, 1);
        cpu_ack = 1'b1;
        settle();
        chk("R4 lowest pending wins", granted, 4'b0010);
        chk("R4 vec of link1", vec_data, 8'h21);
        step();
        cpu_ack = 1'b0;
        step();
        chk("R6 other link still pending", irq_line, 1);
        cpu_ack = 1'b1;
        settle();
        chk("R4 link3 next", granted, 4'b1000);
        chk("R4 vec of link3", vec_data, 8'h23);
        step();
        cpu_ack = 1'b0;
        step();
        chk("R1 line low when all served", irq_line, 0);
    endtask

    task automatic t_program();
        cfg_vec  = 8'hA5;
        cfg_load = 4'b0100;
        step();
        cfg_load = '0;
        cfg_vec  = 8'h5A;
        step();
        pulse_req(4'b0100);
        cpu_ack = 1'b1;
        settle();
        chk("R8 loaded vector", vec_data, 8'hA5);
        step();
        cpu_ack = 1'b0;
        step();
        pulse_req(4'b0001);
        cpu_ack = 1'b1;
        settle();
        chk("R8 link0 keeps reset vector", vec_data, 8'h20);
        step();
        cpu_ack = 1'b0;
        step();
    endtask

    task automatic t_set_wins();
        pulse_req(4'b0010);
        cpu_ack = 1'b1;
        step();
        cpu_ack = 1'b0;
        src_req = 4'b0010;
        step();
        src_req = '0;
        settle();
        chk("R9 new request survives clear", irq_line, 1);
        cpu_ack = 1'b1;
        settle();
        chk("R9 link1 granted again", granted, 4'b0010);
        step();
        cpu_ack = 1'b0;
        step();
        chk("R9 cleared afterwards", irq_line, 0);
    endtask

    task automatic t_late_arrival();
        pulse_req(4'b1000);
        cpu_ack = 1'b1;
        settle();
        chk("R10 link3 granted first", granted, 4'b1000);
        src_req = 4'b0001;
        step();
        src_req = '0;
        settle();
        chk("R7 R10 upstream takes grant", granted, 4'b0001);
        chk("R10 vector of link0", vec_data, 8'h20);
        step();
        cpu_ack = 1'b0;
        step();
        chk("R10 downstream still pending", irq_line, 1);
        cpu_ack = 1'b1;
        settle();
        chk("R10 link3 served next", granted, 4'b1000);
        step();
        cpu_ack = 1'b0;
        step();
        chk("R1 idle at end", irq_line, 0);
    endtask

    initial begin
        rst = 1'b1; src_req = '0; cfg_load = '0; cfg_vec = '0; cpu_ack = 1'b0;
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_passthrough();
        t_single();
        t_priority();
        t_program();
        t_set_wins();
        t_late_arrival();
        serve();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule